// File: doc/BRIEF.md
# Data Address Access Checker

This block sits in front of a data translation buffer. It accepts one load or store request at a time. It resolves which address context the request belongs to and screens the request for privilege and alignment problems. It also recognises accesses to the two internal register windows, so that those accesses never reach the translation buffer. Requests that survive the screening are handed to the translation buffer as a lookup. The buffer's hit or miss answer then finishes the request.

Whenever a fault is raised, three registers record it. A status word describes the fault, and a fault-address register keeps the address of the request. A tag register is loaded on a translation miss only, with the page address merged with the context number.

The control is a four-state machine. ST_IDLE accepts a request when `req_valid_i` is high and latches it, then moves to ST_CHECK. ST_CHECK goes to ST_DONE when the screening finds a fault or the request targets a register window. Otherwise it goes to ST_LOOKUP. ST_LOOKUP holds `tlb_req_o` high until `tlb_rsp_valid_i` arrives, then goes to ST_DONE. ST_DONE raises `done_o` for one cycle and returns to ST_IDLE.

Top module: `dmmu_access_unit`

## Requirements
- R1: The context is selected as follows. With the implicit address-space code 0x00, a trap level above zero selects the nucleus context (`ctx_nucleus_o`=1) with context number 0. A trap level of zero selects the primary context with the number taken from `primary_ctx_i`. With an explicit code, 0x04 selects the nucleus context and every other code selects the primary context.
- R2: An access whose size is 2^`req_size_lg_i` bytes is misaligned when the low address bits ANDed with (size-1) are nonzero. A misaligned access finishes with fault code 2.
- R3: Address-space codes 0x30 to 0x3F are hyperprivileged. Using one of them while `hpstate_i[2]` is 0 gives fault code 1. With `hpstate_i[2]`=1 the request proceeds to lookup.
- R4: Code 0x20 is the scratch window and code 0x21 is the MMU register window. A scratch offset above 0x38 gives fault code 1. An offset from 0x20 to 0x2F gives fault code 1 unless `hpstate_i[2]`=1. Any other window access finishes with fault code 0, `reg_space_o`=1, and no lookup.
- R5: When several checks fail, fault code 1 outranks code 2, and code 2 outranks a translation miss. A faulting request never raises `tlb_req_o`.
- R6: When `pstate_i[3]` is 1, address bits 47 down to 32 are cleared on `tlb_va_o` and in the tag register. Alignment is judged on the unmasked address.
- R7: A lookup hit finishes with code 0. A miss finishes with code 4 when `req_real_i` is 1 and with code 3 otherwise.
- R8: On a miss, `tag_o` becomes the translated address with bits 12 to 0 cleared, ORed with the context number. On any other outcome `tag_o` keeps its value.
- R9: On a fault, `fsr_o` is loaded in the same edge that raises `done_o`. Its layout is {priv `pstate_i[2]` at bit 13, code at bits 12:5, nucleus flag at bit 4, write flag at bit 3, fault code at bits 2:0}. `far_o` is loaded with the unmasked request address in the same edge. Without a fault, neither register changes.
- R10: After reset the machine is in ST_IDLE with `req_ready_o`=1 and `done_o`=0, and `fsr_o`, `far_o` and `tag_o` are zero. `done_o` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, taken in ST_IDLE |
| req_ready_o | output | 1 | High in ST_IDLE |
| req_va_i | input | VA_W | Request virtual address |
| req_size_lg_i | input | 2 | Log2 of access size in bytes |
| req_asi_i | input | 8 | Address-space code |
| req_write_i | input | 1 | Store when high |
| req_real_i | input | 1 | Real-address mode |
| trap_lvl_i | input | TL_W | Trap level |
| pstate_i | input | 4 | Processor state word (bit 2 priv, bit 3 address mask) |
| hpstate_i | input | 4 | Hyper-state word (bit 2 hyperprivilege) |
| primary_ctx_i | input | CTX_W | Primary context number |
| tlb_req_o | output | 1 | Lookup request, high in ST_LOOKUP |
| tlb_va_o | output | VA_W | Lookup address after masking |
| tlb_ctx_o | output | CTX_W | Lookup context number |
| tlb_real_o | output | 1 | Lookup in real mode |
| tlb_rsp_valid_i | input | 1 | Lookup result valid |
| tlb_hit_i | input | 1 | Lookup hit |
| done_o | output | 1 | One-cycle completion strobe |
| fault_o | output | 3 | Fault code (0 none, 1 access exception, 2 misaligned, 3 data miss, 4 real miss) |
| ctx_nucleus_o | output | 1 | Resolved context is nucleus |
| ctx_num_o | output | CTX_W | Resolved context number |
| reg_space_o | output | 1 | Request addressed a register window |
| fsr_o | output | 14 | Fault status register |
| far_o | output | VA_W | Fault address register |
| tag_o | output | VA_W | Tag register |

## Verification
The bench pushes the scratch window through its edges: offsets 0x38, 0x28 with and without hyperprivilege, and 0x40. A design with an off-by-one window would fault at 0x38 or let 0x28 through. It stacks failures, such as a hyperprivileged code on a misaligned address and a misaligned access that would also miss. A wrong priority would report the lower code or issue a lookup it must not. It checks the status and address registers across a faulting and then a clean request, and the tag register with and without the address mask. A register that was loaded too eagerly, or a mask applied to the wrong address, would show up as a wrong stored value.

// File: rtl/dmmu_pkg.sv
package dmmu_pkg;
    typedef enum logic [2:0] {
        FLT_NONE       = 3'd0,
        FLT_ACCESS_EXC = 3'd1,
        FLT_MISALIGN   = 3'd2,
        FLT_DATA_MISS  = 3'd3,
        FLT_REAL_MISS  = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_LOOKUP,
        ST_DONE
    } state_e;

    localparam int          ASI_W        = 8;
    localparam logic [7:0]  ASI_IMPLICIT = 8'h00;
    localparam logic [7:0]  ASI_NUCLEUS  = 8'h04;
    localparam logic [7:0]  ASI_SCRATCH  = 8'h20;
    localparam logic [7:0]  ASI_MMUREG   = 8'h21;
    localparam logic [7:0]  ASI_HP_LO    = 8'h30;
    localparam logic [7:0]  ASI_HP_HI    = 8'h3F;

    localparam int PS_PRIV  = 2;
    localparam int PS_AMASK = 3;
    localparam int HS_HPRIV = 2;
    localparam int FSR_W    = 14;
endpackage

// File: rtl/dmmu_ctx_resolve.sv
module dmmu_ctx_resolve
    import dmmu_pkg::*;
#(
    parameter int TL_W  = 3,
    parameter int CTX_W = 13
) (
    input  logic [ASI_W-1:0] asi_i,
    input  logic [TL_W-1:0]  tl_i,
    input  logic [CTX_W-1:0] primary_i,
    output logic             nucleus_o,
    output logic [CTX_W-1:0] ctx_o
);
    always_comb begin
        if (asi_i == ASI_IMPLICIT) begin
            nucleus_o = (tl_i != '0);
        end else begin
            nucleus_o = (asi_i == ASI_NUCLEUS);
        end
        ctx_o = nucleus_o ? '0 : primary_i;
    end
endmodule

// File: rtl/dmmu_access_check.sv
module dmmu_access_check
    import dmmu_pkg::*;
#(
    parameter int VA_W = 48,
    parameter int AM_W = 32
) (
    input  logic [VA_W-1:0]  va_i,
    input  logic [1:0]       size_lg_i,
    input  logic [ASI_W-1:0] asi_i,
    input  logic             hpriv_i,
    input  logic             amask_i,
    output fault_e           code_o,
    output logic             reg_space_o,
    output logic [VA_W-1:0]  va_xlat_o
);
    localparam logic [VA_W-1:0] SCR_TOP    = VA_W'('h38);
    localparam logic [VA_W-1:0] SCR_HP_LO  = VA_W'('h20);
    localparam logic [VA_W-1:0] SCR_HP_END = VA_W'('h30);

    logic       hp_asi_bad;
    logic       scratch_bad;
    logic       misaligned;
    logic [3:0] size_mask;

    always_comb begin
        size_mask   = (4'd1 << size_lg_i) - 4'd1;
        misaligned  = |(va_i[3:0] & size_mask);
        hp_asi_bad  = (asi_i >= ASI_HP_LO) && (asi_i <= ASI_HP_HI) && !hpriv_i;
        scratch_bad = (asi_i == ASI_SCRATCH) &&
                      ((va_i > SCR_TOP) ||
                       ((va_i >= SCR_HP_LO) && (va_i < SCR_HP_END) && !hpriv_i));
        reg_space_o = (asi_i == ASI_SCRATCH) || (asi_i == ASI_MMUREG);

        if (hp_asi_bad || scratch_bad) begin
            code_o = FLT_ACCESS_EXC;
        end else if (misaligned) begin
            code_o = FLT_MISALIGN;
        end else begin
            code_o = FLT_NONE;
        end

        va_xlat_o = amask_i ? {{(VA_W-AM_W){1'b0}}, va_i[AM_W-1:0]} : va_i;
    end
endmodule

// File: rtl/dmmu_fault_regs.sv
module dmmu_fault_regs
    import dmmu_pkg::*;
#(
    parameter int VA_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flt_load_i,
    input  logic             tag_load_i,
    input  logic [FSR_W-1:0] fsr_d_i,
    input  logic [VA_W-1:0]  far_d_i,
    input  logic [VA_W-1:0]  tag_d_i,
    output logic [FSR_W-1:0] fsr_o,
    output logic [VA_W-1:0]  far_o,
    output logic [VA_W-1:0]  tag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsr_o <= '0;
            far_o <= '0;
            tag_o <= '0;
        end else begin
            if (flt_load_i) begin
                fsr_o <= fsr_d_i;
                far_o <= far_d_i;
            end
            if (tag_load_i) begin
                tag_o <= tag_d_i;
            end
        end
    end
endmodule

// File: rtl/dmmu_access_unit.sv
module dmmu_access_unit
    import dmmu_pkg::*;
#(
    parameter int VA_W  = 48,
    parameter int AM_W  = 32,
    parameter int PG_W  = 13,
    parameter int CTX_W = 13,
    parameter int TL_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic [VA_W-1:0]  req_va_i,
    input  logic [1:0]       req_size_lg_i,
    input  logic [7:0]       req_asi_i,
    input  logic             req_write_i,
    input  logic             req_real_i,
    input  logic [TL_W-1:0]  trap_lvl_i,
    input  logic [3:0]       pstate_i,
    input  logic [3:0]       hpstate_i,
    input  logic [CTX_W-1:0] primary_ctx_i,
    output logic             tlb_req_o,
    output logic [VA_W-1:0]  tlb_va_o,
    output logic [CTX_W-1:0] tlb_ctx_o,
    output logic             tlb_real_o,
    input  logic             tlb_rsp_valid_i,
    input  logic             tlb_hit_i,
    output logic             done_o,
    output logic [2:0]       fault_o,
    output logic             ctx_nucleus_o,
    output logic [CTX_W-1:0] ctx_num_o,
    output logic             reg_space_o,
    output logic [13:0]      fsr_o,
    output logic [VA_W-1:0]  far_o,
    output logic [VA_W-1:0]  tag_o
);
    localparam int TAG_PAD = VA_W - CTX_W;

    state_e            state_q, state_d;
    logic [VA_W-1:0]   va_q;
    logic [1:0]        lg_q;
    logic [ASI_W-1:0]  asi_q;
    logic              wr_q, real_q, priv_q, amask_q, hpriv_q;
    logic [TL_W-1:0]   tl_q;
    logic [CTX_W-1:0]  prim_q;
    fault_e            fault_q, fault_d;
    logic              reg_q;

    fault_e            chk_code;
    logic              chk_reg;
    logic [VA_W-1:0]   va_x;
    logic              nucleus;
    logic [CTX_W-1:0]  ctx_num;
    logic              flt_load, tag_load;
    logic [FSR_W-1:0]  fsr_d;
    logic [VA_W-1:0]   tag_d;
    logic              unused_state_bits;

    assign unused_state_bits = ^{pstate_i[1:0], hpstate_i[3], hpstate_i[1:0]};

    dmmu_ctx_resolve #(.TL_W(TL_W), .CTX_W(CTX_W)) u_ctx (
        .asi_i     (asi_q),
        .tl_i      (tl_q),
        .primary_i (prim_q),
        .nucleus_o (nucleus),
        .ctx_o     (ctx_num)
    );

    dmmu_access_check #(.VA_W(VA_W), .AM_W(AM_W)) u_chk (
        .va_i        (va_q),
        .size_lg_i   (lg_q),
        .asi_i       (asi_q),
        .hpriv_i     (hpriv_q),
        .amask_i     (amask_q),
        .code_o      (chk_code),
        .reg_space_o (chk_reg),
        .va_xlat_o   (va_x)
    );

    // Request latch, taken in ST_IDLE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q    <= '0;
            lg_q    <= '0;
            asi_q   <= '0;
            wr_q    <= 1'b0;
            real_q  <= 1'b0;
            priv_q  <= 1'b0;
            amask_q <= 1'b0;
            hpriv_q <= 1'b0;
            tl_q    <= '0;
            prim_q  <= '0;
        end else if (state_q == ST_IDLE && req_valid_i) begin
            va_q    <= req_va_i;
            lg_q    <= req_size_lg_i;
            asi_q   <= req_asi_i;
            wr_q    <= req_write_i;
            real_q  <= req_real_i;
            priv_q  <= pstate_i[PS_PRIV];
            amask_q <= pstate_i[PS_AMASK];
            hpriv_q <= hpstate_i[HS_HPRIV];
            tl_q    <= trap_lvl_i;
            prim_q  <= primary_ctx_i;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid_i) state_d = ST_CHECK;
            ST_CHECK:  state_d = (chk_code != FLT_NONE || chk_reg) ? ST_DONE : ST_LOOKUP;
            ST_LOOKUP: if (tlb_rsp_valid_i) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Result computation
    always_comb begin
        fault_d  = FLT_NONE;
        flt_load = 1'b0;
        tag_load = 1'b0;
        if (state_q == ST_CHECK) begin
            fault_d  = chk_code;
            flt_load = (chk_code != FLT_NONE);
        end else if (state_q == ST_LOOKUP && tlb_rsp_valid_i && !tlb_hit_i) begin
            fault_d  = real_q ? FLT_REAL_MISS : FLT_DATA_MISS;
            flt_load = 1'b1;
            tag_load = 1'b1;
        end
        fsr_d = {priv_q, asi_q, nucleus, wr_q, fault_d};
        tag_d = {va_x[VA_W-1:PG_W], {PG_W{1'b0}}} | {{TAG_PAD{1'b0}}, ctx_num};
    end

    // Output register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q <= FLT_NONE;
            reg_q   <= 1'b0;
        end else if (state_d == ST_DONE && state_q != ST_DONE) begin
            fault_q <= fault_d;
            reg_q   <= (state_q == ST_CHECK) && chk_reg && (chk_code == FLT_NONE);
        end
    end

    dmmu_fault_regs #(.VA_W(VA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .flt_load_i (flt_load),
        .tag_load_i (tag_load),
        .fsr_d_i    (fsr_d),
        .far_d_i    (va_q),
        .tag_d_i    (tag_d),
        .fsr_o      (fsr_o),
        .far_o      (far_o),
        .tag_o      (tag_o)
    );

    assign req_ready_o   = (state_q == ST_IDLE);
    assign tlb_req_o     = (state_q == ST_LOOKUP);
    assign tlb_va_o      = va_x;
    assign tlb_ctx_o     = ctx_num;
    assign tlb_real_o    = real_q;
    assign done_o        = (state_q == ST_DONE);
    assign fault_o       = fault_q;
    assign reg_space_o   = reg_q;
    assign ctx_nucleus_o = nucleus;
    assign ctx_num_o     = ctx_num;

    // R10
    single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R9
    fsr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o == 3'd0) |-> ($stable(fsr_o) && $stable(far_o)));
    // R8
    tag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o != 3'd3 && fault_o != 3'd4) |-> $stable(tag_o));
    // R5
    lookup_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_req_o |-> (chk_code == FLT_NONE && !chk_reg));
    // R1
    nucleus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_req_o && ctx_nucleus_o) |-> (tlb_ctx_o == '0));
    // R6
    amask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_req_o && amask_q) |-> (tlb_va_o[VA_W-1:AM_W] == '0));
endmodule

// File: tb/dmmu_access_unit_tb.sv
`timescale 1ns/1ps
module dmmu_access_unit_tb;
    typedef struct packed {
        logic [7:0]  asi;
        logic [47:0] va;
        logic [1:0]  lg;
        logic [2:0]  tl;
        logic [3:0]  ps;
        logic [3:0]  hs;
        logic        rl;
        logic        wr;
        logic        hit;
        logic [2:0]  ef;
        logic        ek;
        logic        er;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 48'h1000, 2'd3, 3'd0, 4'h4, 4'h0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 4'd1}, // R1 primary
        '{8'h00, 48'h1000, 2'd3, 3'd1, 4'h4, 4'h0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0, 4'd1}, // R1 nucleus
        '{8'h00, 48'h1004, 2'd3, 3'd0, 4'h4, 4'h0, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0, 4'd2}, // R2
        '{8'h00, 48'h1002, 2'd1, 3'd0, 4'h4, 4'h0, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 4'd2}, // R2
        '{8'h00, 48'h1001, 2'd0, 3'd0, 4'h4, 4'h0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 4'd2}, // R2
        '{8'h35, 48'h1000, 2'd3, 3'd0, 4'h4, 4'h0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 4'd3}, // R3
        '{8'h35, 48'h1000, 2'd3, 3'd0, 4'h4, 4'h4, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 4'd3}, // R3
        '{8'h35, 48'h1003, 2'd2, 3'd0, 4'h4, 4'h0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 4'd5}, // R5
        '{8'h20, 48'h40,   2'd3, 3'd0, 4'h4, 4'h4, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 4'd4}, // R4
        '{8'h20, 48'h28,   2'd3, 3'd0, 4'h4, 4'h0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 4'd4}, // R4
        '{8'h20, 48'h28,   2'd3, 3'd0, 4'h4, 4'h4, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b1, 4'd4}, // R4
        '{8'h20, 48'h38,   2'd3, 3'd0, 4'h4, 4'h0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b1, 4'd4}, // R4
        '{8'h20, 48'h18,   2'd3, 3'd0, 4'h4, 4'h0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b1, 4'd4}, // R4
        '{8'h00, 48'h3000, 2'd3, 3'd0, 4'h4, 4'h0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 4'd7}, // R7
        '{8'h00, 48'h3000, 2'd3, 3'd0, 4'h4, 4'h0, 1'b1, 1'b0, 1'b0, 3'd4, 1'b0, 1'b0, 4'd7}, // R7
        '{8'h00, 48'h3002, 2'd2, 3'd0, 4'h4, 4'h0, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0, 4'd5}, // R5
        '{8'h04, 48'h1000, 2'd3, 3'd0, 4'h4, 4'h0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0, 4'd1}, // R1
        '{8'h21, 48'h8,    2'd3, 3'd0, 4'h4, 4'h0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b1, 4'd4}  // R4
    };

    localparam logic [12:0] PRIM = 13'h0A5C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [47:0] req_va_i = '0;
    logic [1:0]  req_size_lg_i = '0;
    logic [7:0]  req_asi_i = '0;
    logic        req_write_i = 1'b0;
    logic        req_real_i = 1'b0;
    logic [2:0]  trap_lvl_i = '0;
    logic [3:0]  pstate_i = '0;
    logic [3:0]  hpstate_i = '0;
    logic [12:0] primary_ctx_i = PRIM;
    logic        tlb_req_o;
    logic [47:0] tlb_va_o;
    logic [12:0] tlb_ctx_o;
    logic        tlb_real_o;
    logic        tlb_rsp_valid_i = 1'b0;
    logic        tlb_hit_i = 1'b0;
    logic        done_o;
    logic [2:0]  fault_o;
    logic        ctx_nucleus_o;
    logic [12:0] ctx_num_o;
    logic        reg_space_o;
    logic [13:0] fsr_o;
    logic [47:0] far_o;
    logic [47:0] tag_o;

    int n_chk = 0;
    int n_bad = 0;
    int seen_lookup;
    logic [47:0] seen_va;
    logic finished = 1'b0;

    always #4 clk = ~clk;

    dmmu_access_unit u_dut (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_req(input vec_t v, input logic hit);
        @(negedge clk);
        req_asi_i = v.asi; req_va_i = v.va; req_size_lg_i = v.lg;
        trap_lvl_i = v.tl; pstate_i = v.ps; hpstate_i = v.hs;
        req_real_i = v.rl; req_write_i = v.wr; tlb_hit_i = hit;
        req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        seen_lookup = 0;
        seen_va = '0;
        for (int i = 0; i < 20; i++) begin
            if (done_o) break;
            tlb_rsp_valid_i = tlb_req_o;
            if (tlb_req_o) begin
                seen_lookup++;
                seen_va = tlb_va_o;
            end
            @(negedge clk);
        end
        tlb_rsp_valid_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 ready", {63'd0, req_ready_o}, 64'd1);
        check("R10 done", {63'd0, done_o}, 64'd0);
        check("R10 fsr", {50'd0, fsr_o}, 64'd0);
        check("R10 far/tag", {16'd0, far_o | tag_o}, 64'd0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            vec_t v;
            int exp_lk;
            v = VECS[k];
            exp_lk = ((v.ef == 3'd0 && !v.er) || v.ef == 3'd3 || v.ef == 3'd4) ? 1 : 0;
            run_req(v, v.hit);
            check($sformatf("R%0d vec%0d done", v.rq, k), {63'd0, done_o}, 64'd1);
            check($sformatf("R%0d vec%0d fault", v.rq, k), {61'd0, fault_o}, {61'd0, v.ef});
            check($sformatf("R%0d vec%0d nucleus", v.rq, k), {63'd0, ctx_nucleus_o}, {63'd0, v.ek});
            check($sformatf("R%0d vec%0d ctx", v.rq, k), {51'd0, ctx_num_o}, {51'd0, (v.ek ? 13'd0 : PRIM)});
            check($sformatf("R%0d vec%0d regspace", v.rq, k), {63'd0, reg_space_o}, {63'd0, v.er});
            check($sformatf("R5 vec%0d lookups", k), 64'(seen_lookup), 64'(exp_lk));
            @(negedge clk);
            // R10 one-cycle done
            check($sformatf("R10 vec%0d done drop", k), {63'd0, done_o}, 64'd0);
        end

        // R9 status/address capture: hyperprivileged code, store, priv
        run_req('{8'h35, 48'h1000, 2'd3, 3'd0, 4'h4, 4'h0, 1'b0, 1'b1, 1'b1, 3'd1, 1'b0, 1'b0, 4'd9}, 1'b1);
        check("R9 fsr", {50'd0, fsr_o}, 64'h26A9);
        check("R9 far", {16'd0, far_o}, 64'h1000);
        // R9 clean request leaves both untouched
        run_req('{8'h00, 48'h2000, 2'd3, 3'd0, 4'h4, 4'h0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 4'd9}, 1'b1);
        check("R9 fsr held", {50'd0, fsr_o}, 64'h26A9);
        check("R9 far held", {16'd0, far_o}, 64'h1000);

        // R8 tag on virtual miss, primary context
        run_req('{8'h00, 48'h1234_5678, 2'd0, 3'd0, 4'h4, 4'h0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 4'd8}, 1'b0);
        check("R8 tag", {16'd0, tag_o}, 64'h1234_4A5C);
        check("R9 far on miss", {16'd0, far_o}, 64'h1234_5678);
        // R8 tag on nucleus miss (R1 context 0)
        run_req('{8'h00, 48'h6008, 2'd3, 3'd2, 4'h4, 4'h0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b1, 1'b0, 4'd8}, 1'b0);
        check("R8 tag nucleus", {16'd0, tag_o}, 64'h6000);
        // R8 tag unchanged after misaligned fault
        run_req('{8'h00, 48'h7001, 2'd1, 3'd0, 4'h4, 4'h0, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0, 4'd8}, 1'b0);
        check("R8 tag held", {16'd0, tag_o}, 64'h6000);

        // R6 address mask on
        run_req('{8'h00, 48'hABCD_0000_2000, 2'd3, 3'd0, 4'hC, 4'h0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 4'd6}, 1'b0);
        check("R6 masked va", {16'd0, seen_va}, 64'h2000);
        check("R6 masked tag", {16'd0, tag_o}, 64'h2A5C);
        check("R6 far unmasked", {16'd0, far_o}, 64'hABCD_0000_2000);
        // R6 address mask off
        run_req('{8'h00, 48'hABCD_0000_2000, 2'd3, 3'd0, 4'h4, 4'h0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 4'd6}, 1'b1);
        check("R6 unmasked va", {16'd0, seen_va}, 64'hABCD_0000_2000);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule